// File: doc/BRIEF.md
# Local-History Two-Level Direction Predictor

This block guesses whether a conditional branch will be taken. Each branch, chosen by a few low bits of its PC, owns a short shift register that records its most recent outcomes. That history value picks one entry from a single table of 2-bit saturating counters. All branches share this table, so branches with the same recent pattern use the same counter. The upper bit of the chosen counter is the guess. Lookup is combinational, so the guess comes back in the same cycle as the PC.

When a branch resolves, the update port presents its PC and outcome. The counter named by the branch's current history moves one step toward the outcome. The outcome then shifts into the low end of that branch's history. Branches marked unconditional are always reported as taken and never change any state. A parameter swaps the two-level structure for a plain table of per-branch counters with no history, which is useful for comparison.

Top module: `bp_dir_predictor`

## Requirements
- R1: After reset in two-level mode, every history register is 00 and every pattern counter is 00 (strongly not taken), so every conditional lookup returns not taken.
- R2: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. The prediction is the counter's upper bit.
- R3: On a conditional update, the counter adds one when the outcome is taken, stopping at 11, and subtracts one when it is not taken, stopping at 00.
- R4: A history register is selected by PC bits [PC_LSB +: log2(HIST_ENTRIES)], which are bits 4:2 by default. On update, the outcome (1 = taken) enters bit 0 and the oldest bit is dropped.
- R5: The counter that is updated is the one selected by the branch's history as it was before the shift.
- R6: One pattern table serves all branches. A branch that has never been updated but holds the same history value as a trained branch sees the trained counter.
- R7: An update with upd_uncond set changes no state. A lookup with lk_uncond set returns taken.
- R8: When a lookup and an update reach the same entries in one cycle, the lookup returns the state from before the update.
- R9: In flat mode (USE_LOCAL_HIST = 0), each PC slot [PC_LSB +: log2(FLAT_ENTRIES)] has its own counter. Counters reset to 10 (weakly taken) and follow R2 and R3, with no history.
- R10: While upd_valid is low, no state changes, whatever the other update inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_uncond | input | 1 | The looked-up branch is unconditional |
| lk_taken | output | 1 | Direction guess for lk_pc, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_uncond | input | 1 | The resolved branch was unconditional |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A lookup and an update can fall in the same cycle and touch the same history register and counter. This case is forced by a directed cycle that trains and reads the same PC at once. A random phase also drives both ports every cycle with PCs drawn from a narrow range, so slot and history collisions happen often. A behavioural model applies each update only after it has formed that cycle's expected guess. The design is therefore judged against the state from before the edge, in both two-level and flat mode.

// File: rtl/bp_pkg.sv
package bp_pkg;
   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_STRONG_NT = 2'b00;
   localparam ctr_t CTR_WEAK_T    = 2'b10;
   localparam ctr_t CTR_STRONG_T  = 2'b11;

   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken)
         nxt = (cur == CTR_STRONG_T) ? cur : ctr_t'(cur + 2'd1);
      else
         nxt = (cur == CTR_STRONG_NT) ? cur : ctr_t'(cur - 2'd1);
      return nxt;
   endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
   import bp_pkg::*;
#(
   parameter int   DEPTH   = 4,
   parameter ctr_t RST_VAL = CTR_STRONG_NT,
   localparam int  IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("bp_ctr_table: DEPTH must be a power of two of at least 2");
   end

   logic [DEPTH-1:0][1:0] mem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
      end else if (wr_en) begin
         mem[wr_idx] <= ctr_step(mem[wr_idx], wr_taken);
      end
   end

   assign rd_ctr = mem[rd_idx];

   // R10 / R7: no write request, no counter movement
   assert_ctr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mem));

   // R3: taken moves up by at most one step
   assert_ctr_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken) |=> (mem[$past(wr_idx)] >= $past(mem[wr_idx])) &&
                              ((mem[$past(wr_idx)] - $past(mem[wr_idx])) <= 2'd1));

   // R3: not taken moves down by at most one step
   assert_ctr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken) |=> (mem[$past(wr_idx)] <= $past(mem[wr_idx])) &&
                               (($past(mem[wr_idx]) - mem[$past(wr_idx)]) <= 2'd1));
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
   parameter int  DEPTH = 8,
   parameter int  HW    = 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic [HW-1:0]    lk_hist,
   input  logic [IDX_W-1:0] up_idx,
   output logic [HW-1:0]    up_hist,
   input  logic             wr_en,
   input  logic             wr_taken
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("bp_hist_table: DEPTH must be a power of two of at least 2");
   end
   if (HW < 2 || HW > 12) begin : g_bad_hw
      $error("bp_hist_table: HW must lie in 2..12");
   end

   logic [DEPTH-1:0][HW-1:0] hist;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      end else if (wr_en) begin
         hist[up_idx] <= {hist[up_idx][HW-2:0], wr_taken};
      end
   end

   assign lk_hist = hist[lk_idx];
   assign up_hist = hist[up_idx];

   // R4: newest outcome lands in bit 0, older bits move up by one
   assert_hist_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (hist[$past(up_idx)][0] == $past(wr_taken)) &&
                (hist[$past(up_idx)][1] == $past(up_hist[0])));

   // R10 / R7: without a write the histories hold
   assert_hist_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(hist));
endmodule

// File: rtl/bp_dir_predictor.sv
module bp_dir_predictor
   import bp_pkg::*;
#(
   parameter int PC_W           = 32,
   parameter int PC_LSB         = 2,
   parameter int HIST_ENTRIES   = 8,
   parameter int HIST_W         = 2,
   parameter bit USE_LOCAL_HIST = 1'b1,
   parameter int FLAT_ENTRIES   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   input  logic            lk_uncond,
   output logic            lk_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_uncond,
   input  logic            upd_taken
);
   localparam int HIDX_W      = $clog2(HIST_ENTRIES);
   localparam int FIDX_W      = $clog2(FLAT_ENTRIES);
   localparam int PHT_ENTRIES = 1 << HIST_W;

   if (PC_LSB < 1) begin : g_bad_lsb
      $error("bp_dir_predictor: PC_LSB must be at least 1");
   end
   if (PC_W <= PC_LSB + HIDX_W || PC_W <= PC_LSB + FIDX_W) begin : g_bad_pcw
      $error("bp_dir_predictor: PC_W too narrow for the index fields");
   end

   logic  train;
   ctr_t  sel_ctr;

   assign train    = upd_valid && !upd_uncond;
   assign lk_taken = lk_uncond | sel_ctr[1];

   if (USE_LOCAL_HIST) begin : g_two_level
      logic [HIDX_W-1:0] lk_slot, up_slot;
      logic [HIST_W-1:0] lk_hist, up_hist;
      logic              unused_pc_bits;

      assign lk_slot = lk_pc[PC_LSB +: HIDX_W];
      assign up_slot = upd_pc[PC_LSB +: HIDX_W];
      assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+HIDX_W], lk_pc[PC_LSB-1:0],
                                upd_pc[PC_W-1:PC_LSB+HIDX_W], upd_pc[PC_LSB-1:0]};

      bp_hist_table #(
         .DEPTH (HIST_ENTRIES),
         .HW    (HIST_W)
      ) u_hist (
         .clk      (clk),
         .rst_n    (rst_n),
         .lk_idx   (lk_slot),
         .lk_hist  (lk_hist),
         .up_idx   (up_slot),
         .up_hist  (up_hist),
         .wr_en    (train),
         .wr_taken (upd_taken)
      );

      bp_ctr_table #(
         .DEPTH   (PHT_ENTRIES),
         .RST_VAL (CTR_STRONG_NT)
      ) u_pht (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (lk_hist),
         .rd_ctr   (sel_ctr),
         .wr_en    (train),
         .wr_idx   (up_hist),
         .wr_taken (upd_taken)
      );
   end else begin : g_flat
      logic [FIDX_W-1:0] lk_slot, up_slot;
      logic              unused_pc_bits;

      assign lk_slot = lk_pc[PC_LSB +: FIDX_W];
      assign up_slot = upd_pc[PC_LSB +: FIDX_W];
      assign unused_pc_bits = ^{lk_pc[PC_W-1:PC_LSB+FIDX_W], lk_pc[PC_LSB-1:0],
                                upd_pc[PC_W-1:PC_LSB+FIDX_W], upd_pc[PC_LSB-1:0]};

      bp_ctr_table #(
         .DEPTH   (FLAT_ENTRIES),
         .RST_VAL (CTR_WEAK_T)
      ) u_flat (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (lk_slot),
         .rd_ctr   (sel_ctr),
         .wr_en    (train),
         .wr_idx   (up_slot),
         .wr_taken (upd_taken)
      );
   end

   // R7: an unconditional lookup is always reported taken
   assert_uncond_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_uncond |-> lk_taken);
endmodule

// File: tb/bp_dir_predictor_tb.sv
module bp_dir_predictor_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_uncond = 1'b0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_uncond = 1'b0;
   logic        upd_taken = 1'b0;
   logic        pred_two, pred_flat;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // behavioural model state
   int m_hist [8];
   int m_pht  [4];
   int m_flat [8];

   always #10 clk = ~clk;

   bp_dir_predictor #(.USE_LOCAL_HIST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_uncond(lk_uncond),
      .lk_taken(pred_two), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_uncond(upd_uncond), .upd_taken(upd_taken));

   bp_dir_predictor #(.USE_LOCAL_HIST(1'b0)) dut_flat_i (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_uncond(lk_uncond),
      .lk_taken(pred_flat), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_uncond(upd_uncond), .upd_taken(upd_taken));

   function automatic int slot(input logic [31:0] pc);
      return int'(pc[4:2]);
   endfunction

   function automatic int step(input int c, input bit t);
      if (t) return (c == 3) ? 3 : c + 1;
      return (c == 0) ? 0 : c - 1;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin m_hist[i] = 0; m_flat[i] = 2; end
      for (int i = 0; i < 4; i++) m_pht[i] = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; upd_valid = 1'b0; lk_uncond = 1'b0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive, compare both designs against the model, then step the model
   task automatic cyc(input logic [31:0] lpc, input bit luc, input bit uv,
                      input logic [31:0] upc, input bit uuc, input bit ut,
                      input string req);
      int ls, us, h;
      @(negedge clk);
      lk_pc = lpc; lk_uncond = luc;
      upd_valid = uv; upd_pc = upc; upd_uncond = uuc; upd_taken = ut;
      #1;
      ls = slot(lpc);
      check({req, " two-level"}, pred_two,  luc ? 1'b1 : ((m_pht[m_hist[ls]] >> 1) != 0));
      check({req, " flat"},      pred_flat, luc ? 1'b1 : ((m_flat[ls] >> 1) != 0));
      if (uv && !uuc) begin
         us = slot(upc);
         h  = m_hist[us];
         m_pht[h]   = step(m_pht[h], ut);
         m_hist[us] = ((h << 1) | int'(ut)) & 3;
         m_flat[us] = step(m_flat[us], ut);
      end
   endtask

   initial begin : watchdog
      #(200000 * 20);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stim
      do_reset();
      // R1 / R9: reset contents
      cyc(32'h0, 0, 0, 32'h0, 0, 0, "R1");
      check("R1 reset predicts not taken", pred_two, 1'b0);
      check("R9 flat reset weakly taken", pred_flat, 1'b1);
      cyc(32'h1c, 0, 0, 32'h0, 0, 0, "R1");
      // R4 / R5: train PC 0 taken four times: ctr0, ctr1, ctr3, ctr3
      for (int i = 0; i < 4; i++) cyc(32'h0, 0, 1, 32'h0, 0, 1, "R5");
      cyc(32'h0, 0, 0, 32'h0, 0, 0, "R4");
      check("R4 history 11 reaches trained ctr3", pred_two, 1'b1);
      // R6: PC 4 trains ctr0 to 10; PC 8 never trained but history 00 sees it
      cyc(32'h4, 0, 1, 32'h4, 0, 1, "R6");
      cyc(32'h4, 0, 1, 32'h4, 0, 1, "R6");
      cyc(32'h8, 0, 0, 32'h0, 0, 0, "R6");
      check("R6 shared counter seen by untrained PC", pred_two, 1'b1);
      // R8: same-cycle lookup and update on PC 8
      cyc(32'h8, 0, 1, 32'h8, 0, 0, "R8");
      check("R8 lookup sees pre-update state", pred_two, 1'b1);
      cyc(32'h8, 0, 0, 32'h0, 0, 0, "R8");
      check("R8 update visible next cycle", pred_two, 1'b0);
      // R10: update inputs without valid change nothing
      cyc(32'h8, 0, 0, 32'h8, 0, 1, "R10");
      cyc(32'h8, 0, 0, 32'h8, 0, 1, "R10");
      check("R10 no valid no change", pred_two, 1'b0);
      // R7: unconditional update ignored, unconditional lookup taken
      cyc(32'h8, 0, 1, 32'h8, 1, 1, "R7");
      cyc(32'h8, 0, 1, 32'h8, 1, 1, "R7");
      cyc(32'h8, 0, 0, 32'h0, 0, 0, "R7");
      check("R7 uncond update ignored", pred_two, 1'b0);
      cyc(32'h8, 1, 0, 32'h0, 0, 0, "R7");
      check("R7 uncond lookup taken", pred_two, 1'b1);

      // R3 / R2: saturation in flat mode from a fresh reset
      do_reset();
      for (int i = 0; i < 3; i++) cyc(32'h0, 0, 1, 32'h0, 0, 1, "R3");
      cyc(32'h0, 0, 1, 32'h0, 0, 0, "R3");
      cyc(32'h0, 0, 1, 32'h0, 0, 0, "R3");
      check("R2 flat 10 predicts taken", pred_flat, 1'b1);
      cyc(32'h0, 0, 0, 32'h0, 0, 0, "R3");
      check("R2 flat 01 predicts not taken", pred_flat, 1'b0);
      for (int i = 0; i < 3; i++) cyc(32'h0, 0, 1, 32'h0, 0, 0, "R3");
      cyc(32'h0, 0, 1, 32'h0, 0, 1, "R3");
      cyc(32'h0, 0, 1, 32'h0, 0, 1, "R3");
      check("R3 floor at 00 then 01", pred_flat, 1'b0);
      cyc(32'h0, 0, 0, 32'h0, 0, 0, "R3");
      check("R3 rises to 10", pred_flat, 1'b1);

      // R2 / R8: random traffic over a narrow PC range, model compared each clock
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] lpc, upc;
         bit luc, uv, uuc, ut;
         lpc = {27'd0, 3'($urandom_range(0, 7)), 2'b00};
         upc = ($urandom_range(0, 3) == 0) ? lpc : {27'd0, 3'($urandom_range(0, 7)), 2'b00};
         lpc[31:5] = 27'($urandom);
         luc = ($urandom_range(0, 9) == 0);
         uv  = ($urandom_range(0, 4) != 0);
         uuc = ($urandom_range(0, 7) == 0);
         ut  = ($urandom_range(0, 2) != 0);
         cyc(lpc, luc, uv, upc, uuc, ut, "R2 random");
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule